// File: doc/BRIEF.md
# Mixed-Width Unified Instruction and Data Memory

This block is a 2 KB memory shared by the instruction side and the data side of a 32-bit processor with separate instruction and data buses. It has two ports. The fetch port is read-only. It takes a halfword address and returns 16 bits. The data port takes a word address and reads or writes 32 bits. Writes go through four active-low byte enables, so the port can write 8-bit, 16-bit and 32-bit quantities.

The storage is split into four banks that are each one byte wide, one bank per byte lane. Both ports see every bank at byte width. The fetch side picks two adjacent bank outputs and joins them into a halfword. As a result, the two ports share one big-endian view of memory, and each lane keeps its own write enable. Code that the processor writes through the data port can therefore be fetched without any bypass path.

Top module: `unified_mem`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first read completes, `fetch_data` and `data_rdata` are zero.
- R2: The data port addresses 512 words and the fetch port addresses 1024 halfwords of the same storage. Fetch address h reads word h[9:1], including the lowest word (0) and the highest word (511).
- R3: Byte lane k of the addressed word is written only in a cycle where `data_en`=1, `data_wr_n`=0 and `data_be_n[k]`=0. With any one of these missing, the stored contents do not change.
- R4: A write that enables one, two or all four lanes replaces exactly the enabled bytes and leaves the other bytes of the word unchanged.
- R5: The memory is big-endian. Lane k holds byte address 4w+k and sits on `data_wdata`/`data_rdata` bits [31-8k:24-8k]. Lane 0 is bits 31:24 and lane 3 is bits 7:0.
- R6: `fetch_addr[0]`=0 returns {lane 0, lane 1} and `fetch_addr[0]`=1 returns {lane 2, lane 3}. The first lane named is on bits 15:8.
- R7: Both ports return data one clock after the address is presented. A fetch and a data read of the same word in the same cycle return matching halves.
- R8: If the data port writes a word in the same cycle that the fetch port reads it, the fetch returns the contents from before the write.
- R9: `data_rdata` updates only in cycles with `data_en`=1 and otherwise holds its last value. A data-port write cycle also returns the word's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| fetch_addr | input | 10 | Halfword address of the fetch port |
| fetch_data | output | 16 | Fetched halfword, one cycle after the address |
| data_en | input | 1 | Data port enable |
| data_wr_n | input | 1 | Data port write strobe, active low |
| data_be_n | input | 4 | Per-lane write enables, active low, bit k selects lane k |
| data_addr | input | 9 | Word address of the data port |
| data_wdata | input | 32 | Write data, big-endian lanes |
| data_rdata | output | 32 | Read data, one cycle after an enabled access |

## Verification
The cross-port assertions assume that the storage cells they compare have been written at least once. An unwritten cell has no defined value, so the two ports cannot be expected to agree on it. The stimulus fills every word with a full 32-bit write before it fetches or reads that word, and only then applies partial writes. The stimulus also keeps all inputs at defined levels from time zero. Inputs change only on the falling clock edge.

// File: rtl/umem_pkg.sv
package umem_pkg;

    // Width of one storage lane
    localparam int unsigned LANE_W = 8;

    // Number of halfwords in one word on the fetch side
    localparam int unsigned HW_PER_WORD = 2;

    // Number of halfword-select bits carried by a fetch address
    localparam int unsigned HW_SEL_W = $clog2(HW_PER_WORD);

    typedef logic [LANE_W-1:0] lane_t;

endpackage

// File: rtl/umem_bank.sv
module umem_bank
    import umem_pkg::*;
#(
    parameter int unsigned AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    output lane_t         a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  lane_t         b_wdata,
    output lane_t         b_rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        lane_t a;
        lane_t b;
    } rd_t;

    lane_t mem_q [DEPTH];
    rd_t   rd_d;
    rd_t   rd_q;

    always_comb begin
        rd_d   = rd_q;
        rd_d.a = mem_q[a_addr];
        if (b_en) begin
            rd_d.b = mem_q[b_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    // Storage array: no reset, written only on the data side
    always_ff @(posedge clk) begin
        if (b_en && b_we) begin
            mem_q[b_addr] <= b_wdata;
        end
    end

    assign a_rdata = rd_q.a;
    assign b_rdata = rd_q.b;

    AST_BANK_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |-> b_en); // R3

    AST_BANK_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_rdata)); // R9

    AST_BANK_REREAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && b_en && !b_we && $past(b_en) && !$past(b_we)
         && (b_addr == $past(b_addr))) |=> $stable(b_rdata)); // R3

endmodule

// File: rtl/umem_lane_gate.sv
module umem_lane_gate
    import umem_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                    en,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES-1:0]        lane_we,
    output lane_t [LANES-1:0]       lane_wdata
);

    logic strobe;

    always_comb begin
        strobe = en && !wr_n;
    end

    // Lane k carries the k-th byte counted from the most significant end
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            lane_we[k]    = strobe && !be_n[k];
            lane_wdata[k] = wdata[(LANES-1-k)*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/umem_fetch_sel.sv
module umem_fetch_sel
    import umem_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [HW_SEL_W-1:0]               sel_in,
    input  lane_t [LANES-1:0]                 lane_rd,
    output logic [(LANES/HW_PER_WORD)*LANE_W-1:0] hw_out
);

    localparam int unsigned HALF = LANES / HW_PER_WORD;

    typedef struct packed {
        logic [HW_SEL_W-1:0] sel;
    } st_t;

    st_t st_d;
    st_t st_q;

    // The select bit is delayed so that it lines up with the registered bank outputs
    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        hw_out = '0;
        for (int j = 0; j < HALF; j++) begin
            hw_out[(HALF-1-j)*LANE_W +: LANE_W] = lane_rd[int'(st_q.sel)*HALF + j];
        end
    end

endmodule

// File: rtl/unified_mem.sv
module unified_mem
    import umem_pkg::*;
#(
    parameter int unsigned WORD_AW = 9,
    parameter int unsigned LANES   = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [WORD_AW+HW_SEL_W-1:0]           fetch_addr,
    output logic [(LANES/HW_PER_WORD)*LANE_W-1:0] fetch_data,
    input  logic                                  data_en,
    input  logic                                  data_wr_n,
    input  logic [LANES-1:0]                      data_be_n,
    input  logic [WORD_AW-1:0]                    data_addr,
    input  logic [LANES*LANE_W-1:0]               data_wdata,
    output logic [LANES*LANE_W-1:0]               data_rdata
);

    localparam int unsigned WORD_W = LANES * LANE_W;
    localparam int unsigned HW_W   = (LANES / HW_PER_WORD) * LANE_W;
    localparam int unsigned FA_W   = WORD_AW + HW_SEL_W;

    logic [LANES-1:0]   lane_we;
    lane_t [LANES-1:0]  lane_wdata;
    lane_t [LANES-1:0]  lane_a_rd;
    lane_t [LANES-1:0]  lane_b_rd;
    logic [WORD_AW-1:0] fetch_word;

    always_comb begin
        fetch_word = fetch_addr[FA_W-1:HW_SEL_W];
    end

    umem_lane_gate #(
        .LANES (LANES)
    ) i_gate (
        .en         (data_en),
        .wr_n       (data_wr_n),
        .be_n       (data_be_n),
        .wdata      (data_wdata),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        umem_bank #(
            .AW (WORD_AW)
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_addr  (fetch_word),
            .a_rdata (lane_a_rd[k]),
            .b_en    (data_en),
            .b_we    (lane_we[k]),
            .b_addr  (data_addr),
            .b_wdata (lane_wdata[k]),
            .b_rdata (lane_b_rd[k])
        );

        always_comb begin
            data_rdata[(LANES-1-k)*LANE_W +: LANE_W] = lane_b_rd[k];
        end
    end

    umem_fetch_sel #(
        .LANES (LANES)
    ) i_fsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_in  (fetch_addr[HW_SEL_W-1:0]),
        .lane_rd (lane_a_rd),
        .hw_out  (fetch_data)
    );

    AST_VIEW_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && (fetch_addr[HW_SEL_W-1:0] == '0) && (fetch_word == data_addr))
        |=> (fetch_data == data_rdata[WORD_W-1 -: HW_W])); // R7

    AST_VIEW_LOWER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && (fetch_addr[HW_SEL_W-1:0] == '1) && (fetch_word == data_addr))
        |=> (fetch_data == data_rdata[HW_W-1:0])); // R6

    AST_NO_LANE_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_en || data_wr_n) |-> (lane_we == '0)); // R3

endmodule

// File: tb/test_unified_mem.sv
module test_unified_mem;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  fetch_addr = '0;
    logic [15:0] fetch_data;
    logic        data_en = 1'b0;
    logic        data_wr_n = 1'b1;
    logic [3:0]  data_be_n = 4'hF;
    logic [8:0]  data_addr = '0;
    logic [31:0] data_wdata = '0;
    logic [31:0] data_rdata;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    unified_mem i_unified_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data),
        .data_en    (data_en),
        .data_wr_n  (data_wr_n),
        .data_be_n  (data_be_n),
        .data_addr  (data_addr),
        .data_wdata (data_wdata),
        .data_rdata (data_rdata)
    );

    // Entry fields: word address, fill value, lane enables (active low), write data, expected word
    localparam logic [108:0] TBL [8] = '{
        {9'h000, 32'h11223344, 4'b1110, 32'hAABBCCDD, 32'hAA223344},
        {9'h001, 32'h11223344, 4'b1101, 32'hAABBCCDD, 32'h11BB3344},
        {9'h002, 32'h11223344, 4'b1011, 32'hAABBCCDD, 32'h1122CC44},
        {9'h003, 32'h11223344, 4'b0111, 32'hAABBCCDD, 32'h112233DD},
        {9'h004, 32'h11223344, 4'b1100, 32'hAABBCCDD, 32'hAABB3344},
        {9'h005, 32'h11223344, 4'b0011, 32'hAABBCCDD, 32'h1122CCDD},
        {9'h1FF, 32'h11223344, 4'b0000, 32'hAABBCCDD, 32'hAABBCCDD},
        {9'h100, 32'h11223344, 4'b1111, 32'hAABBCCDD, 32'h11223344}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        data_en    = 1'b0;
        data_wr_n  = 1'b1;
        data_be_n  = 4'hF;
    endtask

    task automatic dwrite(input logic [8:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        data_en = 1'b1; data_wr_n = 1'b0; data_be_n = be; data_addr = a; data_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic dread(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        data_en = 1'b1; data_wr_n = 1'b1; data_addr = a;
        @(negedge clk);
        idle();
        d = data_rdata;
    endtask

    task automatic fread(input logic [9:0] a, output logic [15:0] h);
        @(negedge clk);
        fetch_addr = a;
        @(negedge clk);
        h = fetch_data;
    endtask

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [15:0] h;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 fetch in reset", {16'h0, fetch_data}, 32'h0);
        chk("R1 data in reset", data_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data after release", data_rdata, 32'h0);

        // Table: partial writes on a filled word, read back on both ports
        for (int i = 0; i < 8; i++) begin
            logic [8:0]  a;
            logic [31:0] fill;
            logic [3:0]  be;
            logic [31:0] wd;
            logic [31:0] exp;
            {a, fill, be, wd, exp} = TBL[i];
            dwrite(a, 4'h0, fill);
            dwrite(a, be, wd);
            dread(a, w);
            chk("R4 R5 data readback", w, exp);
            fread({a, 1'b0}, h);
            chk("R6 R2 fetch upper", {16'h0, h}, {16'h0, exp[31:16]});
            fread({a, 1'b1}, h);
            chk("R6 R2 fetch lower", {16'h0, h}, {16'h0, exp[15:0]});
        end

        // R5: word assembled from four byte writes, fetched as two halfwords
        dwrite(9'h020, 4'b1110, 32'hDE000000);
        dwrite(9'h020, 4'b1101, 32'h00AD0000);
        dwrite(9'h020, 4'b1011, 32'h0000BE00);
        dwrite(9'h020, 4'b0111, 32'h000000EF);
        fread(10'h040, h);
        chk("R5 byte-built upper half", {16'h0, h}, 32'h0000DEAD);
        fread(10'h041, h);
        chk("R5 byte-built lower half", {16'h0, h}, 32'h0000BEEF);
        dread(9'h020, w);
        chk("R5 byte-built word", w, 32'hDEADBEEF);

        // R3: incomplete write conditions leave storage unchanged
        dwrite(9'h030, 4'h0, 32'h55667788);
        @(negedge clk);
        data_en = 1'b0; data_wr_n = 1'b0; data_be_n = 4'h0; data_addr = 9'h030; data_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        data_en = 1'b1; data_wr_n = 1'b1;
        @(negedge clk);
        data_wr_n = 1'b0; data_be_n = 4'hF;
        @(negedge clk);
        idle();
        dread(9'h030, w);
        chk("R3 no write without all enables", w, 32'h55667788);

        // R9: output holds while disabled
        @(negedge clk);
        data_addr = 9'h000;
        repeat (3) @(negedge clk);
        chk("R9 hold while disabled", data_rdata, 32'h55667788);

        // R9: write cycle returns old contents on the data port
        @(negedge clk);
        data_en = 1'b1; data_wr_n = 1'b0; data_be_n = 4'h0; data_addr = 9'h030; data_wdata = 32'h0BADF00D;
        @(negedge clk);
        idle();
        chk("R9 read-before-write data port", data_rdata, 32'h55667788);
        dread(9'h030, w);
        chk("R9 new value after write", w, 32'h0BADF00D);

        // R8: fetch in the same cycle as a write sees the old contents
        dwrite(9'h010, 4'h0, 32'h01020304);
        @(negedge clk);
        fetch_addr = {9'h010, 1'b0};
        data_en = 1'b1; data_wr_n = 1'b0; data_be_n = 4'h0; data_addr = 9'h010; data_wdata = 32'hA1A2A3A4;
        @(negedge clk);
        idle();
        chk("R8 fetch old contents", {16'h0, fetch_data}, 32'h00000102);
        @(negedge clk);
        chk("R8 fetch new contents", {16'h0, fetch_data}, 32'h0000A1A2);

        // R7: one-cycle latency and matching halves on both ports
        @(negedge clk);
        fetch_addr = {9'h010, 1'b1};
        data_en = 1'b1; data_wr_n = 1'b1; data_addr = 9'h010;
        @(negedge clk);
        idle();
        chk("R7 fetch latency", {16'h0, fetch_data}, 32'h0000A3A4);
        chk("R7 data latency", data_rdata, 32'hA1A2A3A4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule